// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Controller

This block is the status and interrupt front end for the transmit and receive FIFOs of an SPI controller. It watches the fill counts of both FIFOs, the push and pop strobes around them and a busy indication from the serial engine. From these it builds a 5-bit status word and a 5-bit raw interrupt vector. Two interrupt sources follow the FIFO levels against thresholds that software programs. The other three are sticky error flags: transmit overflow, receive underflow and receive overflow.

Software writes four registers through a small write port. These are the transmit threshold, the receive threshold, the interrupt mask and a write-only clear register. A threshold write is kept only if the value fits below the FIFO depth, so software can find the depth by writing a value and reading it back. The masked vector and a single OR-reduced interrupt line go to the interrupt controller. The FIFO storage and the shift engine sit outside this block.

Each sticky flag is a two-state machine with the states FLAG_IDLE and FLAG_HELD. The transition IDLE to HELD happens on the flag's error event. The transition HELD to IDLE happens on a matching clear, but only when no error event arrives in the same cycle.

Top module: `sfi_ctrl`

## Requirements
- R1: One clock edge after the inputs are sampled, status reflects them: bit0 busy, bit1 transmit level equals transmit depth, bit2 transmit level is zero, bit3 receive level is zero, bit4 receive level equals receive depth.
- R2: Raw interrupt bit0 is 1, one edge after sampling, exactly when the transmit level is at or below the transmit threshold.
- R3: Raw interrupt bit4 is 1, one edge after sampling, exactly when the receive level is strictly greater than the receive threshold.
- R4: A transmit push while the transmit level equals the transmit depth sets raw bit1 at that edge, and the bit stays set until cleared. A push below full leaves it alone.
- R5: A receive pop while the receive level is zero sets raw bit2, and the bit stays set until cleared.
- R6: A receive push while the receive level equals the receive depth sets raw bit3, and the bit stays set until cleared.
- R7: A write with select 3 is a clear. Data bit1 clears raw bit2, data bit2 clears raw bit3, data bit3 clears raw bit1, and data bit0 clears all three. Uncleared flags are kept.
- R8: When a clear and an error event hit the same flag in the same cycle, the flag ends up set.
- R9: A write with select 0 sets the transmit threshold and select 1 sets the receive threshold. The value is taken only if it is less than the matching depth. Otherwise the old threshold is kept.
- R10: A write with select 2 loads the mask from data bits 4:0. The masked vector is raw AND mask, and irq is 1 exactly when any masked bit is 1.
- R11: While reset is asserted, status, raw, masked vector, irq, both thresholds and the mask are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eng_busy | input | 1 | Serial engine busy |
| tx_depth | input | LVL_W | Transmit FIFO depth |
| rx_depth | input | LVL_W | Receive FIFO depth |
| tx_level | input | LVL_W | Transmit FIFO fill count |
| rx_level | input | LVL_W | Receive FIFO fill count |
| tx_push | input | 1 | Bus-side write into transmit FIFO |
| rx_push | input | 1 | Engine write into receive FIFO |
| rx_pop | input | 1 | Bus-side read from receive FIFO |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 tx threshold, 1 rx threshold, 2 mask, 3 clear |
| reg_wdata | input | DATA_W | Write data |
| tx_thresh | output | LVL_W | Transmit threshold readback |
| rx_thresh | output | LVL_W | Receive threshold readback |
| irq_mask | output | 5 | Mask readback |
| status | output | 5 | Status word |
| raw_irq | output | 5 | Unmasked interrupt vector |
| masked_irq | output | 5 | Masked interrupt vector |
| irq | output | 1 | Interrupt line |

## Verification
The hardest case to reach is the race between a clear write and a new error event on the same flag in the same cycle. The bench holds the transmit level at the full depth and raises a push in the same half-cycle as a clear-all write, so both arrive at one edge. It then also drives events on two flags at once and clears only one of them. This shows that the clear decode picks flags by bit and does not wipe the whole vector.

// File: rtl/sfi_pkg.sv
package sfi_pkg;
    typedef enum logic [1:0] {
        SEL_TX_THR = 2'd0,
        SEL_RX_THR = 2'd1,
        SEL_MASK   = 2'd2,
        SEL_CLEAR  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_HELD = 1'b1
    } flag_state_e;

    localparam int NUM_IRQ = 5;
    localparam int NUM_ERR = 3;

    // raw vector positions
    localparam int IRQ_TX_LOW  = 0;
    localparam int IRQ_TX_OVF  = 1;
    localparam int IRQ_RX_UDF  = 2;
    localparam int IRQ_RX_OVF  = 3;
    localparam int IRQ_RX_HIGH = 4;

    // clear register positions
    localparam int CLR_ALL    = 0;
    localparam int CLR_RX_UDF = 1;
    localparam int CLR_RX_OVF = 2;
    localparam int CLR_TX_OVF = 3;
endpackage

// File: rtl/sfi_level_decode.sv
module sfi_level_decode
    import sfi_pkg::*;
#(
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy_i,
    input  logic [LVL_W-1:0] tx_depth_i,
    input  logic [LVL_W-1:0] rx_depth_i,
    input  logic [LVL_W-1:0] tx_level_i,
    input  logic [LVL_W-1:0] rx_level_i,
    input  logic             tx_push_i,
    input  logic             rx_push_i,
    input  logic             rx_pop_i,
    input  logic [LVL_W-1:0] tx_thr_i,
    input  logic [LVL_W-1:0] rx_thr_i,
    output logic [4:0]       status_o,
    output logic [1:0]       thr_hit_o,
    output logic [NUM_ERR-1:0] err_ev_o
);
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic [4:0] status_d, status_q;
    logic [1:0] thr_d, thr_q;

    always_comb begin
        tx_full  = (tx_level_i == tx_depth_i);
        tx_empty = (tx_level_i == '0);
        rx_full  = (rx_level_i == rx_depth_i);
        rx_empty = (rx_level_i == '0);
        status_d = {rx_full, rx_empty, tx_empty, tx_full, busy_i};
        thr_d    = {(rx_level_i > rx_thr_i), (tx_level_i <= tx_thr_i)};
        // index 0 tx overflow, 1 rx underflow, 2 rx overflow
        err_ev_o = {rx_push_i & rx_full, rx_pop_i & rx_empty, tx_push_i & tx_full};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            thr_q    <= '0;
        end else begin
            status_q <= status_d;
            thr_q    <= thr_d;
        end
    end

    assign status_o  = status_q;
    assign thr_hit_o = thr_q;

    assert_tx_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level_i == '0) |=> status_o[2]);
    assert_rx_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level_i != rx_depth_i) |=> !status_o[4]);
    assert_tx_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level_i > tx_thr_i) |=> !thr_hit_o[0]);
    assert_rx_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level_i > rx_thr_i) |=> thr_hit_o[1]);
endmodule

// File: rtl/sfi_sticky_flag.sv
module sfi_sticky_flag
    import sfi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: if (set_i) state_d = FLAG_HELD;
            FLAG_HELD: if (clr_i && !set_i) state_d = FLAG_IDLE;
            default:   state_d = FLAG_IDLE;
        endcase
    end

    always_comb begin
        flag_o = (state_q == FLAG_HELD);
    end

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
    assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !set_i) |=> !flag_o);
endmodule

// File: rtl/sfi_cfg_regs.sv
module sfi_cfg_regs
    import sfi_pkg::*;
#(
    parameter int LVL_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [1:0]        sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [LVL_W-1:0]  tx_depth_i,
    input  logic [LVL_W-1:0]  rx_depth_i,
    output logic [LVL_W-1:0]  tx_thr_o,
    output logic [LVL_W-1:0]  rx_thr_o,
    output logic [NUM_IRQ-1:0] mask_o,
    output logic [NUM_ERR-1:0] err_clr_o
);
    localparam int CMP_W = (DATA_W > LVL_W) ? DATA_W : LVL_W;

    logic [LVL_W-1:0] tx_thr_q, rx_thr_q;
    logic [NUM_IRQ-1:0] mask_q;
    logic [CMP_W-1:0] wide_data, wide_tx_depth, wide_rx_depth;
    logic tx_ok, rx_ok, clr_wr;

    always_comb begin
        wide_data     = CMP_W'(wdata_i);
        wide_tx_depth = CMP_W'(tx_depth_i);
        wide_rx_depth = CMP_W'(rx_depth_i);
        tx_ok  = wr_i && (sel_i == SEL_TX_THR) && (wide_data < wide_tx_depth);
        rx_ok  = wr_i && (sel_i == SEL_RX_THR) && (wide_data < wide_rx_depth);
        clr_wr = wr_i && (sel_i == SEL_CLEAR);
        // flag order: tx overflow, rx underflow, rx overflow
        err_clr_o[0] = clr_wr && (wdata_i[CLR_TX_OVF] || wdata_i[CLR_ALL]);
        err_clr_o[1] = clr_wr && (wdata_i[CLR_RX_UDF] || wdata_i[CLR_ALL]);
        err_clr_o[2] = clr_wr && (wdata_i[CLR_RX_OVF] || wdata_i[CLR_ALL]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_thr_q <= '0;
            rx_thr_q <= '0;
            mask_q   <= '0;
        end else begin
            if (tx_ok) tx_thr_q <= wdata_i[LVL_W-1:0];
            if (rx_ok) rx_thr_q <= wdata_i[LVL_W-1:0];
            if (wr_i && (sel_i == SEL_MASK)) mask_q <= wdata_i[NUM_IRQ-1:0];
        end
    end

    assign tx_thr_o = tx_thr_q;
    assign rx_thr_o = rx_thr_q;
    assign mask_o   = mask_q;

    assert_tx_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == SEL_TX_THR && wide_data >= wide_tx_depth) |=> $stable(tx_thr_o));
    assert_rx_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == SEL_RX_THR && wide_data >= wide_rx_depth) |=> $stable(rx_thr_o));
    assert_mask_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && sel_i == SEL_MASK) |=> $stable(mask_o));
endmodule

// File: rtl/sfi_ctrl.sv
module sfi_ctrl
    import sfi_pkg::*;
#(
    parameter int DEPTH_MAX = 32,
    parameter int DATA_W    = 8,
    localparam int LVL_W    = $clog2(DEPTH_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eng_busy,
    input  logic [LVL_W-1:0]  tx_depth,
    input  logic [LVL_W-1:0]  rx_depth,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              tx_push,
    input  logic              rx_push,
    input  logic              rx_pop,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [LVL_W-1:0]  tx_thresh,
    output logic [LVL_W-1:0]  rx_thresh,
    output logic [4:0]        irq_mask,
    output logic [4:0]        status,
    output logic [4:0]        raw_irq,
    output logic [4:0]        masked_irq,
    output logic              irq
);
    logic [1:0]         thr_hit;
    logic [NUM_ERR-1:0] err_ev, err_clr, err_flag;

    sfi_cfg_regs #(.LVL_W(LVL_W), .DATA_W(DATA_W)) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .sel_i(reg_sel),
        .wdata_i(reg_wdata), .tx_depth_i(tx_depth), .rx_depth_i(rx_depth),
        .tx_thr_o(tx_thresh), .rx_thr_o(rx_thresh), .mask_o(irq_mask),
        .err_clr_o(err_clr)
    );

    sfi_level_decode #(.LVL_W(LVL_W)) dec_i (
        .clk(clk), .rst_n(rst_n), .busy_i(eng_busy),
        .tx_depth_i(tx_depth), .rx_depth_i(rx_depth),
        .tx_level_i(tx_level), .rx_level_i(rx_level),
        .tx_push_i(tx_push), .rx_push_i(rx_push), .rx_pop_i(rx_pop),
        .tx_thr_i(tx_thresh), .rx_thr_i(rx_thresh),
        .status_o(status), .thr_hit_o(thr_hit), .err_ev_o(err_ev)
    );

    for (genvar g = 0; g < NUM_ERR; g++) begin : g_err
        sfi_sticky_flag flag_i (
            .clk(clk), .rst_n(rst_n), .set_i(err_ev[g]),
            .clr_i(err_clr[g]), .flag_o(err_flag[g])
        );
    end

    always_comb begin
        raw_irq              = '0;
        raw_irq[IRQ_TX_LOW]  = thr_hit[0];
        raw_irq[IRQ_TX_OVF]  = err_flag[0];
        raw_irq[IRQ_RX_UDF]  = err_flag[1];
        raw_irq[IRQ_RX_OVF]  = err_flag[2];
        raw_irq[IRQ_RX_HIGH] = thr_hit[1];
        masked_irq           = raw_irq & irq_mask;
        irq                  = |masked_irq;
    end

    assert_tx_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && tx_level == tx_depth) |=> raw_irq[IRQ_TX_OVF]);
    assert_rx_udf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && rx_level == '0) |=> raw_irq[IRQ_RX_UDF]);
    assert_rx_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_level == rx_depth) |=> raw_irq[IRQ_RX_OVF]);
    assert_quiet_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_irq == '0) |-> !irq);
endmodule

// File: tb/sfi_ctrl_tb_top.sv
module sfi_ctrl_tb_top;
    localparam int LW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic eng_busy = 1'b0;
    logic [LW-1:0] tx_depth = 6'd8, rx_depth = 6'd8, tx_level = '0, rx_level = '0;
    logic tx_push = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic reg_wr = 1'b0;
    logic [1:0] reg_sel = '0;
    logic [7:0] reg_wdata = '0;
    logic [LW-1:0] tx_thresh, rx_thresh;
    logic [4:0] irq_mask, status, raw_irq, masked_irq;
    logic irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sfi_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .eng_busy(eng_busy),
        .tx_depth(tx_depth), .rx_depth(rx_depth),
        .tx_level(tx_level), .rx_level(rx_level),
        .tx_push(tx_push), .rx_push(rx_push), .rx_pop(rx_pop),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .tx_thresh(tx_thresh), .rx_thresh(rx_thresh), .irq_mask(irq_mask),
        .status(status), .raw_irq(raw_irq), .masked_irq(masked_irq), .irq(irq)
    );

    // {busy, tx_level, rx_level, expected status, expected {rx_high, tx_low}}
    // depths 8, tx threshold 3, rx threshold 5
    localparam logic [19:0] VEC [6] = '{
        {1'b0, 6'd0, 6'd0, 5'b01100, 2'b01},
        {1'b1, 6'd8, 6'd8, 5'b10011, 2'b10},
        {1'b0, 6'd3, 6'd5, 5'b00000, 2'b01},
        {1'b0, 6'd4, 6'd6, 5'b00000, 2'b10},
        {1'b1, 6'd0, 6'd8, 5'b10101, 2'b11},
        {1'b0, 6'd8, 6'd0, 5'b01010, 2'b00}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        tx_push = 1'b0; rx_push = 1'b0; rx_pop = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic wr(logic [1:0] sel, logic [7:0] data);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
        step();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 status", status, 0);
        check("R11 raw", raw_irq, 0);
        check("R11 cfg", {tx_thresh, rx_thresh, irq_mask, irq}, 0);
        rst_n = 1'b1;
        wr(2'd0, 8'd3);
        wr(2'd1, 8'd5);
        check("R9 accept tx", tx_thresh, 3);
        check("R9 accept rx", rx_thresh, 5);

        for (int i = 0; i < 6; i++) begin
            eng_busy = VEC[i][19];
            tx_level = VEC[i][18:13];
            rx_level = VEC[i][12:7];
            step();
            check("R1 status", status, VEC[i][6:2]);
            check("R2 tx low", raw_irq[0], VEC[i][0]);
            check("R3 rx high", raw_irq[4], VEC[i][1]);
        end
        eng_busy = 1'b0;

        // R9 rejection at depth boundary
        wr(2'd0, 8'd8);
        check("R9 reject tx", tx_thresh, 3);
        wr(2'd0, 8'd7);
        check("R9 accept tx 7", tx_thresh, 7);
        wr(2'd1, 8'd20);
        check("R9 reject rx", rx_thresh, 5);

        // R4 push below full does nothing
        tx_level = 6'd5; rx_level = 6'd0; step();
        tx_push = 1'b1; step();
        check("R4 no ovf below full", raw_irq, 5'b00001);
        tx_level = 6'd8; step();
        tx_push = 1'b1; step();
        check("R4 tx overflow", raw_irq, 5'b00010);
        step();
        check("R4 sticky", raw_irq, 5'b00010);
        rx_pop = 1'b1; step();
        check("R5 rx underflow", raw_irq, 5'b00110);
        rx_level = 6'd8; rx_push = 1'b1; step();
        check("R6 rx overflow", raw_irq, 5'b11110);
        rx_level = 6'd0; step();
        check("R6 sticky", raw_irq, 5'b01110);

        // R7 individual and global clears
        wr(2'd3, 8'b0100);
        check("R7 clear rx ovf", raw_irq, 5'b00110);
        wr(2'd3, 8'b0010);
        check("R7 clear rx udf", raw_irq, 5'b00010);
        wr(2'd3, 8'b1000);
        check("R7 clear tx ovf", raw_irq, 5'b00000);
        tx_push = 1'b1; rx_pop = 1'b1; step();
        check("R7 two set", raw_irq, 5'b00110);
        wr(2'd3, 8'b1000);
        check("R7 partial keeps other", raw_irq, 5'b00100);
        wr(2'd3, 8'b0001);
        check("R7 clear all", raw_irq, 5'b00000);

        // R8 clear and event together
        tx_push = 1'b1;
        wr(2'd3, 8'b0001);
        check("R8 set wins", raw_irq, 5'b00010);

        // R10 masking
        wr(2'd2, 8'b00010);
        check("R10 mask readback", irq_mask, 5'b00010);
        check("R10 masked", {masked_irq, irq}, {5'b00010, 1'b1});
        wr(2'd2, 8'b11101);
        check("R10 blocked", {masked_irq, irq}, {5'b00000, 1'b0});

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule